// File: doc/BRIEF.md
# Flash In-System Programming Command Controller

This block lets software read, erase and program a small embedded non-volatile word array through a handful of bus registers. Software first opens a write-protection lock with a three-word key sequence. It then sets the enable and per-region update permissions in the control register. Next it loads a command code, a word address and a data word, and finally sets a launch bit. The controller checks the request and, if it is legal, runs it against the array over a fixed number of cycles. While the operation runs it shows busy. When the operation ends, the launch bit clears by itself.

The array has three regions: the application region, the boot region and the user configuration region. Erase and program are refused for any region whose update permission is off. An illegal request is dropped: no array word changes. The request completes in one cycle, and a sticky fail flag is raised. Only software clears that flag, by writing 1 to it. The flag does not stop later commands from running.

Top module: `flash_isp_ctrl`

## Requirements
- R1: After reset, every register reads 0, the lock is closed, and the busy and fail outputs are 0. Register reads return the addressed register one clock after `bus_addr` is presented. Register addresses: 0 control, 1 command, 2 address, 3 data, 4 launch, 5 key.
- R2: The lock opens after three consecutive bus writes to the key register (address 5) whose low bytes are KEY0, KEY1 and KEY2 (defaults 0xA5, 0x3C, 0xE1). Any other bus write in between restarts the sequence. Reading the key register returns bit 0 = 1 while the lock is open. Writing the key register while the lock is open closes it.
- R3: Control bits 0 (enable), 1 (boot update), 2 (configuration update) and 3 (application update) take a written value only while the lock is open. Writes made while the lock is closed leave them unchanged.
- R4: Writing 1 to bit 0 of the launch register while idle sets busy and launch bit 0 on the following clock. For a legal request, both clear by hardware exactly LATENCY clocks after the launch write (default 8).
- R5: Command code 0 (read) loads the addressed word into the data register by the time busy clears.
- R6: Command code 1 (program) replaces the addressed word with its old value AND the data register.
- R7: Command code 2 (erase) sets every word of the PAGE_WORDS-aligned page (default 4 words) that holds the address to all ones. Words outside that page keep their values.
- R8: A request is illegal, and is then dropped with busy high for one clock only, no array change and the fail flag (control bit 4 and output `fail`) set, in any of these cases: enable is 0; the command code is 3; the address is at or beyond the end of the array; or the command is erase or program and the update permission of the target region is 0. The regions are application at words 0–31, boot at words 32–39 and configuration at words 40–43. A read of an in-range word needs no update permission.
- R9: The fail flag stays set through later legal commands and through control writes with bit 4 = 0. Writing 1 to control bit 4 clears it, whether or not the lock is open. If a clearing write and a new failure fall on the same clock, the flag ends set.
- R10: While busy, writes to the command, address, data and launch registers are ignored. A launch write during busy does not lengthen the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address for writes and reads |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Registered read data of the addressed register |
| busy | output | 1 | Operation in progress |
| fail | output | 1 | Sticky fail flag |

## Verification
The fail flag has two writers that can act in the same clock: the hardware that raises it when a launched request proves illegal, and a software write of 1 that clears it. The bench launches an undefined command. On the very next bus cycle, it writes the control register with bit 4 set, so the clearing write lands on the same edge as the hardware set. The result is judged by reading the flag afterwards: it must still be 1. A separate clear must then bring it back to 0.

// File: rtl/isp_pkg.sv
package isp_pkg;
  typedef enum logic [1:0] {
    CMD_READ  = 2'd0,
    CMD_PROG  = 2'd1,
    CMD_ERASE = 2'd2,
    CMD_RSVD  = 2'd3
  } isp_cmd_e;

  localparam logic [2:0] RA_CTRL = 3'd0;
  localparam logic [2:0] RA_CMD  = 3'd1;
  localparam logic [2:0] RA_ADDR = 3'd2;
  localparam logic [2:0] RA_DATA = 3'd3;
  localparam logic [2:0] RA_GO   = 3'd4;
  localparam logic [2:0] RA_KEY  = 3'd5;
endpackage

// File: rtl/isp_unlock.sv
module isp_unlock #(
  parameter logic [7:0] KEY0 = 8'hA5,
  parameter logic [7:0] KEY1 = 8'h3C,
  parameter logic [7:0] KEY2 = 8'hE1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic       is_key,
  input  logic [7:0] wbyte,
  output logic       unlocked
);
  logic [1:0] stage_q;
  logic [7:0] expect_key;

  always_comb begin
    case (stage_q)
      2'd0:    expect_key = KEY0;
      2'd1:    expect_key = KEY1;
      default: expect_key = KEY2;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= 2'd0;
    end else if (wr) begin
      if (stage_q == 2'd3) begin
        if (is_key) stage_q <= 2'd0;
      end else if (is_key && wbyte == expect_key) begin
        stage_q <= stage_q + 2'd1;
      end else if (is_key && wbyte == KEY0) begin
        stage_q <= 2'd1;
      end else begin
        stage_q <= 2'd0;
      end
    end
  end

  assign unlocked = (stage_q == 2'd3);

  // R2: the lock opens only right after the last key word was written
  a_r2_open_after_last_key: assert property (@(posedge clk) disable iff (rst)
    $rose(unlocked) |-> $past(wr && is_key && wbyte == KEY2));
endmodule

// File: rtl/isp_region_check.sv
module isp_region_check #(
  parameter int AW         = 6,
  parameter int APP_WORDS  = 32,
  parameter int BOOT_WORDS = 8,
  parameter int CFG_WORDS  = 4
) (
  input  isp_pkg::isp_cmd_e cmd,
  input  logic [AW-1:0]     addr,
  input  logic              en,
  input  logic              boot_upd,
  input  logic              cfg_upd,
  input  logic              app_upd,
  output logic              err
);
  import isp_pkg::*;
  localparam int BOOT_BASE = APP_WORDS;
  localparam int CFG_BASE  = APP_WORDS + BOOT_WORDS;
  localparam int TOTAL     = CFG_BASE + CFG_WORDS;

  logic [31:0] a32;
  logic        in_range, in_app, in_boot, region_ok, modifies;

  always_comb begin
    a32       = 32'(addr);
    in_range  = a32 < 32'(TOTAL);
    in_app    = a32 < 32'(BOOT_BASE);
    in_boot   = !in_app && a32 < 32'(CFG_BASE);
    region_ok = in_app ? app_upd : (in_boot ? boot_upd : cfg_upd);
    modifies  = (cmd == CMD_PROG) || (cmd == CMD_ERASE);
    err = !en || (cmd == CMD_RSVD) || !in_range || (modifies && !region_ok);
  end
endmodule

// File: rtl/isp_mem.sv
module isp_mem #(
  parameter int AW    = 6,
  parameter int DW    = 32,
  parameter int DEPTH = 44
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/flash_isp_ctrl.sv
module flash_isp_ctrl #(
  parameter int         DW         = 32,
  parameter int         AW         = 6,
  parameter int         APP_WORDS  = 32,
  parameter int         BOOT_WORDS = 8,
  parameter int         CFG_WORDS  = 4,
  parameter int         PAGE_WORDS = 4,
  parameter int         LATENCY    = 8,
  parameter logic [7:0] KEY0       = 8'hA5,
  parameter logic [7:0] KEY1       = 8'h3C,
  parameter logic [7:0] KEY2       = 8'hE1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          busy,
  output logic          fail
);
  import isp_pkg::*;
  localparam int TOTAL = APP_WORDS + BOOT_WORDS + CFG_WORDS;
  localparam int PGW   = $clog2(PAGE_WORDS);
  localparam int CW    = $clog2(LATENCY + 1);

  logic          en_q, boot_q, cfg_q, app_q, fail_q;
  isp_cmd_e      cmd_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          busy_q, first_q;
  logic [CW-1:0] cnt_q;
  logic          unlocked, err, last;
  logic          wr_ctrl, wr_cmd, wr_addr, wr_data, wr_go, wr_key;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata, mem_q;

  assign wr_ctrl = bus_wr && bus_addr == RA_CTRL;
  assign wr_cmd  = bus_wr && bus_addr == RA_CMD;
  assign wr_addr = bus_wr && bus_addr == RA_ADDR;
  assign wr_data = bus_wr && bus_addr == RA_DATA;
  assign wr_go   = bus_wr && bus_addr == RA_GO;
  assign wr_key  = bus_wr && bus_addr == RA_KEY;

  isp_unlock #(.KEY0(KEY0), .KEY1(KEY1), .KEY2(KEY2)) u_lock (
    .clk(clk), .rst(rst), .wr(bus_wr), .is_key(wr_key),
    .wbyte(bus_wdata[7:0]), .unlocked(unlocked)
  );

  isp_region_check #(.AW(AW), .APP_WORDS(APP_WORDS), .BOOT_WORDS(BOOT_WORDS),
                     .CFG_WORDS(CFG_WORDS)) u_chk (
    .cmd(cmd_q), .addr(addr_q), .en(en_q), .boot_upd(boot_q),
    .cfg_upd(cfg_q), .app_upd(app_q), .err(err)
  );

  // Operation sequencing: error check in the first busy cycle, array
  // read in that cycle, erase writes across the first PAGE_WORDS cycles,
  // program write and read capture in the last cycle.
  assign last = cnt_q == CW'(LATENCY - 1);

  always_comb begin
    mem_re    = busy_q && first_q && !err && cmd_q != CMD_ERASE;
    mem_we    = 1'b0;
    mem_waddr = addr_q;
    mem_wdata = mem_q & data_q;
    if (busy_q && cmd_q == CMD_ERASE) begin
      mem_we    = (32'(cnt_q) < 32'(PAGE_WORDS)) && !(first_q && err);
      mem_waddr = {addr_q[AW-1:PGW], cnt_q[PGW-1:0]};
      mem_wdata = '1;
    end else if (busy_q && cmd_q == CMD_PROG && !first_q) begin
      mem_we = last;
    end
  end

  isp_mem #(.AW(AW), .DW(DW), .DEPTH(TOTAL)) u_mem (
    .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
    .re(mem_re), .raddr(addr_q), .rdata(mem_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q    <= 1'b0;
      boot_q  <= 1'b0;
      cfg_q   <= 1'b0;
      app_q   <= 1'b0;
      fail_q  <= 1'b0;
      cmd_q   <= CMD_READ;
      addr_q  <= '0;
      data_q  <= '0;
      busy_q  <= 1'b0;
      first_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      if (wr_ctrl && unlocked) begin
        en_q   <= bus_wdata[0];
        boot_q <= bus_wdata[1];
        cfg_q  <= bus_wdata[2];
        app_q  <= bus_wdata[3];
      end
      if (busy_q && first_q && err) fail_q <= 1'b1;
      else if (wr_ctrl && bus_wdata[4]) fail_q <= 1'b0;

      if (!busy_q) begin
        if (wr_cmd)  cmd_q  <= isp_cmd_e'(bus_wdata[1:0]);
        if (wr_addr) addr_q <= bus_wdata[AW-1:0];
        if (wr_data) data_q <= bus_wdata;
        if (wr_go && bus_wdata[0]) begin
          busy_q  <= 1'b1;
          first_q <= 1'b1;
          cnt_q   <= '0;
        end
      end else begin
        first_q <= 1'b0;
        if (first_q && err) begin
          busy_q <= 1'b0;
        end else if (last) begin
          busy_q <= 1'b0;
          if (cmd_q == CMD_READ) data_q <= mem_q;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        RA_CTRL: bus_rdata <= DW'({fail_q, app_q, cfg_q, boot_q, en_q});
        RA_CMD:  bus_rdata <= DW'(cmd_q);
        RA_ADDR: bus_rdata <= DW'(addr_q);
        RA_DATA: bus_rdata <= data_q;
        RA_GO:   bus_rdata <= DW'(busy_q);
        RA_KEY:  bus_rdata <= DW'(unlocked);
        default: bus_rdata <= '0;
      endcase
    end
  end

  assign busy = busy_q;
  assign fail = fail_q;

  // R3: permission bits hold while the lock is closed
  a_r3_ctrl_locked: assert property (@(posedge clk) disable iff (rst)
    !unlocked |=> $stable({en_q, boot_q, cfg_q, app_q}));
  // R4: an idle launch write starts an operation
  a_r4_launch: assert property (@(posedge clk) disable iff (rst)
    (!busy_q && wr_go && bus_wdata[0]) |=> busy_q);
  // R8: an illegal request ends at once and raises the flag
  a_r8_fail_fast: assert property (@(posedge clk) disable iff (rst)
    (busy_q && first_q && err) |=> (fail_q && !busy_q));
  // R8: no array write while the request is judged illegal
  a_r8_no_write: assert property (@(posedge clk) disable iff (rst)
    (busy_q && first_q && err) |-> !mem_we);
  // R9: the flag only drops on a clearing write
  a_r9_sticky: assert property (@(posedge clk) disable iff (rst)
    (fail_q && !(wr_ctrl && bus_wdata[4])) |=> fail_q);
  // R10: request registers hold during an operation
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    busy_q |=> ($stable(addr_q) && $stable(cmd_q) && (cmd_q != CMD_READ || $stable(data_q) || !busy_q)));
endmodule

// File: tb/sim_flash_isp_ctrl.sv
module sim_flash_isp_ctrl;
  localparam int LAT = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        busy, fail;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  flash_isp_ctrl u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy), .fail(fail)
  );

  always #4 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // All tasks start and end just after a falling edge.
  task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [31:0] v);
    bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    v = bus_rdata;
  endtask

  task automatic wait_idle(output int bc);
    bc = 0;
    while (busy && bc < 100) begin bc++; @(negedge clk); end
  endtask

  task automatic run_cmd(input logic [1:0] c, input logic [5:0] a,
                         input logic [31:0] d, output int bc);
    bus_write(3'd1, 32'(c));
    bus_write(3'd2, 32'(a));
    bus_write(3'd3, d);
    bus_write(3'd4, 32'd1);
    wait_idle(bc);
  endtask

  task automatic rd_word(input logic [5:0] a, output logic [31:0] v);
    int bc;
    run_cmd(2'd0, a, 32'd0, bc);
    bus_read(3'd3, v);
  endtask

  task automatic unlock();
    bus_write(3'd5, 32'hA5);
    bus_write(3'd5, 32'h3C);
    bus_write(3'd5, 32'hE1);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 busy", 32'(busy), 0);
    chk("R1 fail", 32'(fail), 0);
    for (int i = 0; i < 6; i++) begin
      bus_read(3'(i), v);
      chk("R1 reg reset", v, 0);
    end
  endtask

  task automatic t_lock();
    logic [31:0] v;
    bus_write(3'd0, 32'hF);
    bus_read(3'd0, v); chk("R3 locked write ignored", v, 0);
    bus_write(3'd5, 32'hA5); bus_write(3'd5, 32'h3C);
    bus_write(3'd3, 32'h0); bus_write(3'd5, 32'hE1);
    bus_read(3'd5, v); chk("R2 interrupted sequence", v, 0);
    unlock();
    bus_read(3'd5, v); chk("R2 unlocked", v, 1);
    bus_write(3'd0, 32'hF);
    bus_read(3'd0, v); chk("R3 unlocked write", v, 32'hF);
    bus_write(3'd5, 32'h0);
    bus_read(3'd5, v); chk("R2 relock", v, 0);
    bus_write(3'd0, 32'h0);
    bus_read(3'd0, v); chk("R3 relocked write ignored", v, 32'hF);
    unlock();
  endtask

  task automatic t_erase_program();
    logic [31:0] v;
    int bc;
    run_cmd(2'd2, 6'd9, 32'd0, bc);
    chk("R4 busy length", 32'(bc), LAT);
    for (int i = 8; i < 12; i++) begin
      rd_word(6'(i), v); chk("R7 page erased", v, 32'hFFFF_FFFF);
    end
    run_cmd(2'd1, 6'd8, 32'h1234_5678, bc);
    rd_word(6'd8, v); chk("R5 R6 program then read", v, 32'h1234_5678);
    run_cmd(2'd2, 6'd4, 32'd0, bc);
    rd_word(6'd8, v); chk("R7 other page untouched", v, 32'h1234_5678);
    rd_word(6'd7, v); chk("R7 page top word", v, 32'hFFFF_FFFF);
    run_cmd(2'd1, 6'd5, 32'hF0F0_FFFF, bc);
    run_cmd(2'd1, 6'd5, 32'hFF00_FF0F, bc);
    rd_word(6'd5, v); chk("R6 AND program", v, 32'hF000_FF0F);
    bus_read(3'd4, v); chk("R4 go self-cleared", v, 0);
  endtask

  task automatic t_errors();
    logic [31:0] v;
    int bc;
    bus_write(3'd0, 32'hE);
    run_cmd(2'd1, 6'd5, 32'h0, bc);
    chk("R8 disabled one cycle", 32'(bc), 1);
    chk("R8 disabled fail", 32'(fail), 1);
    bus_write(3'd0, 32'h1F);
    chk("R9 clear", 32'(fail), 0);
    rd_word(6'd5, v); chk("R8 disabled no change", v, 32'hF000_FF0F);
    run_cmd(2'd3, 6'd5, 32'h0, bc);
    chk("R8 undefined cmd", 32'(fail), 1);
    bus_write(3'd0, 32'h1F);
    run_cmd(2'd0, 6'd44, 32'h0, bc);
    chk("R8 out of range one cycle", 32'(bc), 1);
    chk("R8 out of range", 32'(fail), 1);
    bus_write(3'd0, 32'h1D);
    run_cmd(2'd1, 6'd33, 32'h0, bc);
    chk("R8 boot protected", 32'(fail), 1);
    bus_write(3'd0, 32'h1D);
    run_cmd(2'd0, 6'd33, 32'h0, bc);
    chk("R8 read needs no permission", 32'(fail), 0);
    chk("R8 read full length", 32'(bc), LAT);
    bus_write(3'd0, 32'h1B);
    run_cmd(2'd2, 6'd40, 32'h0, bc);
    chk("R8 config protected", 32'(fail), 1);
    bus_write(3'd0, 32'h17);
    run_cmd(2'd1, 6'd5, 32'h0, bc);
    chk("R8 app protected", 32'(fail), 1);
    bus_write(3'd0, 32'hF);
    rd_word(6'd5, v); chk("R8 app protected no change", v, 32'hF000_FF0F);
  endtask

  task automatic t_sticky();
    logic [31:0] v;
    int bc;
    chk("R9 still set", 32'(fail), 1);
    run_cmd(2'd0, 6'd8, 32'h0, bc);
    chk("R9 set through legal cmd", 32'(fail), 1);
    bus_read(3'd3, v); chk("R9 legal cmd ran", v, 32'h1234_5678);
    bus_write(3'd0, 32'hF);
    chk("R9 bit4=0 keeps flag", 32'(fail), 1);
    bus_write(3'd5, 32'h0);
    bus_write(3'd0, 32'h10);
    chk("R9 clear while locked", 32'(fail), 0);
    bus_read(3'd0, v); chk("R3 enables kept", v, 32'hF);
    unlock();
  endtask

  task automatic t_collide();
    logic [31:0] v;
    int bc;
    bus_write(3'd1, 32'd3);
    bus_write(3'd4, 32'd1);
    bus_write(3'd0, 32'h1F);
    wait_idle(bc);
    chk("R9 set wins over clear", 32'(fail), 1);
    bus_write(3'd0, 32'h1F);
    chk("R9 clear after collision", 32'(fail), 0);
  endtask

  task automatic t_busy_ignore();
    logic [31:0] v;
    int bc;
    bus_write(3'd1, 32'd1);
    bus_write(3'd2, 32'd6);
    bus_write(3'd3, 32'hA5A5_0000);
    bus_write(3'd4, 32'd1);
    bus_write(3'd1, 32'd0);
    bus_write(3'd2, 32'd7);
    bus_write(3'd3, 32'h0);
    bus_write(3'd4, 32'd1);
    wait_idle(bc);
    chk("R10 launch not extended", 32'(bc + 4), LAT);
    bus_read(3'd1, v); chk("R10 cmd held", v, 1);
    bus_read(3'd2, v); chk("R10 addr held", v, 6);
    bus_read(3'd3, v); chk("R10 data held", v, 32'hA5A5_0000);
    rd_word(6'd6, v); chk("R10 program used held data", v, 32'hA5A5_0000);
    rd_word(6'd7, v); chk("R10 other word untouched", v, 32'hFFFF_FFFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_lock();
    t_erase_program();
    t_errors();
    t_sticky();
    t_collide();
    t_busy_ignore();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule